// File: doc/BRIEF.md
# Paged Register File with Retention Bytes

This block is a byte-wide register file on a plain synchronous register bus with an 8-bit address, 8-bit write data, a write enable, a read enable and 8-bit read data. The lower half of the address space (0x00 to 0x7F) is a functional region that looks the same whatever page is selected. The upper half (0x80 to 0xFF) is an extended window. A page register inside the functional region chooses which extended register set appears in that window.

Two extended pages are implemented, numbered 1 and 2. Each page holds four read/write scratch bytes at 0x80 to 0x83. Four general-purpose bytes at 0x1C to 0x1F sit in a separate backup reset domain. They survive a main reset and are cleared only by the backup reset. Any address that maps to nothing reads as zero and ignores writes.

Top module: `paged_regfile`

## Requirements
- R1: While the main reset `rstN` is low, and after it is released, the page register at 0x7F reads 0x00 and every scratch byte on both pages reads 0x00.
- R2: A write to address 0x7F stores all 8 bits of the write data in the page register. A later read of 0x7F returns that value.
- R3: Functional addresses (bit 7 of the address clear) return the same contents whichever page value is selected. They need no page write first.
- R4: With page 1 (0x01) or page 2 (0x02) selected, addresses 0x80 to 0x83 are read/write scratch bytes that belong to that page alone. A write made on one page is never visible on the other.
- R5: While the page register holds any value other than 0x01 or 0x02, every extended address (bit 7 set) reads 0x00, and writes there change no stored byte.
- R6: Reserved addresses read 0x00 and ignore writes. These are the functional addresses other than 0x1C to 0x1F and 0x7F, and the extended addresses 0x84 to 0xFF on a valid page.
- R7: Addresses 0x1C to 0x1F are four read/write bytes. They keep their contents through a main reset and are cleared to 0x00 only by the backup reset `bkpRstN`.
- R8: Writes take effect on the rising clock edge where `busWe` is high. Read data is combinational from the address and the current register contents, so a read of 0x7F in the same cycle as a write to it shows the old page value.
- R9: `busRdata` is 0x00 whenever `busRe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Main reset, active low, asynchronous |
| bkpRstN | input | 1 | Backup-domain reset for the retention bytes, active low, asynchronous |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busRe | input | 1 | Read enable; gates the read data |
| busRdata | output | 8 | Combinational read data |

## Verification
The assertions assume that the bus inputs are steady across each rising edge and that the backup reset is asserted at least once before retention contents are relied on. The retention-hold property is disabled only by the backup reset, so it also assumes that the main reset alone never disturbs those bytes. The bench drives every bus input on the falling edge and asserts both resets together at time zero. It pulses each reset by itself later, and it samples read data a short delay after the falling edge, before the next rising edge.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int NUM_PAGES   = 2;
  localparam int SCRATCH_CNT = 4;
  localparam int RETAIN_CNT  = 4;
  localparam int RETAIN_BASE = 'h1C;
  localparam int PAGE_ADDR   = 'h7F;
  localparam int EXT_BASE    = 'h80;
  localparam int SIDX_W      = (SCRATCH_CNT > 1) ? $clog2(SCRATCH_CNT) : 1;
  localparam int RIDX_W      = (RETAIN_CNT > 1) ? $clog2(RETAIN_CNT) : 1;
  localparam int PG_W        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  typedef enum logic [1:0] {RD_ZERO, RD_PAGE, RD_RETAIN, RD_EXT} rdSel_e;

  typedef struct packed {
    logic              wrPage;
    logic              wrRetain;
    logic              wrExt;
    rdSel_e            rdSel;
    logic [RIDX_W-1:0] retIdx;
    logic [SIDX_W-1:0] extIdx;
    logic [PG_W-1:0]   pageIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] curPage,
  output ctlStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] RetLo   = ADDR_W'(RETAIN_BASE);
  localparam logic [ADDR_W-1:0] RetHi   = ADDR_W'(RETAIN_BASE + RETAIN_CNT);
  localparam logic [ADDR_W-1:0] PageA   = ADDR_W'(PAGE_ADDR);
  localparam logic [ADDR_W-1:0] ExtLo   = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] ExtSpan = ADDR_W'(SCRATCH_CNT);
  localparam logic [DATA_W-1:0] MaxPage = DATA_W'(NUM_PAGES);

  logic [ADDR_W-1:0] extOff, retOff;
  logic pageOk, extHit, retHit, pageHit;

  always_comb begin
    extOff  = busAddr - ExtLo;
    retOff  = busAddr - RetLo;
    pageOk  = (curPage != '0) && (curPage <= MaxPage);
    extHit  = busAddr[ADDR_W-1] && pageOk && (extOff < ExtSpan);
    retHit  = (busAddr >= RetLo) && (busAddr < RetHi);
    pageHit = (busAddr == PageA);

    strb          = '0;
    strb.wrPage   = busWe && pageHit;
    strb.wrRetain = busWe && retHit;
    strb.wrExt    = busWe && extHit;
    strb.retIdx   = retOff[RIDX_W-1:0];
    strb.extIdx   = extOff[SIDX_W-1:0];
    strb.pageIdx  = PG_W'(curPage - 1'b1);
    if (!busRe)       strb.rdSel = RD_ZERO;
    else if (pageHit) strb.rdSel = RD_PAGE;
    else if (retHit)  strb.rdSel = RD_RETAIN;
    else if (extHit)  strb.rdSel = RD_EXT;
    else              strb.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bkpRstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pageQ
);
  logic [RETAIN_CNT-1:0][DATA_W-1:0]                  retainQ;
  logic [NUM_PAGES-1:0][SCRATCH_CNT-1:0][DATA_W-1:0]  scratchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pageQ <= '0;
    else if (strb.wrPage) pageQ <= busWdata;
  end

  // Backup domain: main reset does not reach these bytes.
  always_ff @(posedge clk or negedge bkpRstN) begin
    if (!bkpRstN)           retainQ <= '0;
    else if (strb.wrRetain) retainQ[strb.retIdx] <= busWdata;
  end

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        scratchQ[g] <= '0;
      else if (strb.wrExt && (strb.pageIdx == PG_W'(g)))
        scratchQ[g][strb.extIdx] <= busWdata;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_PAGE:   busRdata = pageQ;
      RD_RETAIN: busRdata = retainQ[strb.retIdx];
      RD_EXT:    busRdata = scratchQ[strb.pageIdx][strb.extIdx];
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bkpRstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata
);
  ctlStrobes_t       strb;
  logic [DATA_W-1:0] curPage;

  prf_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .curPage (curPage),
    .strb    (strb)
  );

  prf_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bkpRstN  (bkpRstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pageQ    (curPage)
  );
endmodule

// File: rtl/paged_regfile_chk.sv
module paged_regfile_chk
  import prf_pkg::*;
(
  input logic                                          clk,
  input logic                                          rstN,
  input logic                                          bkpRstN,
  input logic [ADDR_W-1:0]                             busAddr,
  input logic [DATA_W-1:0]                             busWdata,
  input logic                                          busWe,
  input logic                                          busRe,
  input logic [DATA_W-1:0]                             busRdata,
  input logic [DATA_W-1:0]                             pageQ,
  input logic [RETAIN_CNT-1:0][DATA_W-1:0]             retainQ,
  input logic [NUM_PAGES-1:0][SCRATCH_CNT-1:0][DATA_W-1:0] scratchQ
);
  logic pageOk, retAddr, pageAddr;
  assign pageOk   = (pageQ != '0) && (pageQ <= DATA_W'(NUM_PAGES));
  assign retAddr  = (busAddr >= ADDR_W'(RETAIN_BASE)) &&
                    (busAddr < ADDR_W'(RETAIN_BASE + RETAIN_CNT));
  assign pageAddr = (busAddr == ADDR_W'(PAGE_ADDR));

  p_page_reset_r1: assert property (@(posedge clk) !rstN |-> pageQ == '0);

  p_page_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && pageAddr) |=> pageQ == $past(busWdata));

  p_page_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && pageAddr) |-> busRdata == pageQ);

  p_ext_blank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr[ADDR_W-1] && !pageOk) |-> busRdata == '0);

  p_scratch_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pageOk |=> $stable(scratchQ));

  p_retain_hold_r7: assert property (@(posedge clk) disable iff (!bkpRstN)
    !(busWe && retAddr) |=> $stable(retainQ));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == '0);
endmodule

bind paged_regfile paged_regfile_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bkpRstN  (bkpRstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRdata (busRdata),
  .pageQ    (curPage),
  .retainQ  (u_dp.retainQ),
  .scratchQ (u_dp.scratchQ)
);

// File: tb/paged_regfile_bench.sv
`timescale 1ns/1ps
module paged_regfile_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bkpRstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic       busRe = 1'b0;
  logic [7:0] busRdata;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paged_regfile u_paged_regfile (
    .clk(clk), .rstN(rstN), .bkpRstN(bkpRstN), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; busRe = 1'b0;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0;
  endtask

  task automatic expectRead(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    expectRead("R1 page reg after reset", 8'h7F, 8'h00);
    @(negedge clk); busAddr = 8'h7F; busRe = 1'b0;
    #1 check("R9 rdata idle", busRdata, 8'h00);
  endtask

  task automatic t_page_reg;
    busWrite(8'h7F, 8'hA5);
    expectRead("R2 page reg readback", 8'h7F, 8'hA5);
    expectRead("R5 ext blank on page 0xA5", 8'h80, 8'h00);
  endtask

  task automatic t_isolation;
    busWrite(8'h7F, 8'h01);
    for (int i = 0; i < 4; i++) busWrite(8'h80 + 8'(i), 8'h10 + 8'(i));
    busWrite(8'h7F, 8'h02);
    for (int i = 0; i < 4; i++) expectRead("R4 page2 untouched", 8'h80 + 8'(i), 8'h00);
    for (int i = 0; i < 4; i++) busWrite(8'h80 + 8'(i), 8'h20 + 8'(i));
    for (int i = 0; i < 4; i++) expectRead("R4 page2 data", 8'h80 + 8'(i), 8'h20 + 8'(i));
    busWrite(8'h7F, 8'h01);
    for (int i = 0; i < 4; i++) expectRead("R4 page1 data", 8'h80 + 8'(i), 8'h10 + 8'(i));
  endtask

  task automatic t_invalid_page;
    busWrite(8'h7F, 8'h05);
    expectRead("R5 ext blank page 5", 8'h81, 8'h00);
    busWrite(8'h80, 8'hEE);
    busWrite(8'h7F, 8'h00);
    busWrite(8'h81, 8'hDD);
    expectRead("R5 ext blank page 0", 8'h81, 8'h00);
    busWrite(8'h7F, 8'h01);
    expectRead("R5 page1 0x80 unchanged", 8'h80, 8'h10);
    expectRead("R5 page1 0x81 unchanged", 8'h81, 8'h11);
    busWrite(8'h7F, 8'h02);
    expectRead("R5 page2 0x80 unchanged", 8'h80, 8'h20);
  endtask

  task automatic t_reserved;
    busWrite(8'h50, 8'h77);
    expectRead("R6 functional reserved", 8'h50, 8'h00);
    busWrite(8'h00, 8'h66);
    expectRead("R6 address 0x00", 8'h00, 8'h00);
    busWrite(8'h84, 8'h99);
    expectRead("R6 ext reserved 0x84", 8'h84, 8'h00);
    busWrite(8'hFF, 8'h98);
    expectRead("R6 ext reserved 0xFF", 8'hFF, 8'h00);
    expectRead("R6 neighbour 0x83 intact", 8'h83, 8'h23);
  endtask

  task automatic t_functional;
    for (int i = 0; i < 4; i++) busWrite(8'h1C + 8'(i), 8'hC0 + 8'(i));
    for (int p = 0; p < 4; p++) begin
      busWrite(8'h7F, 8'(p));
      for (int i = 0; i < 4; i++)
        expectRead("R3 R7 retention same on every page", 8'h1C + 8'(i), 8'hC0 + 8'(i));
    end
  endtask

  task automatic t_same_cycle;
    busWrite(8'h7F, 8'h01);
    @(negedge clk);
    busAddr = 8'h7F; busWdata = 8'h02; busWe = 1'b1; busRe = 1'b1;
    #1 check("R8 old page before edge", busRdata, 8'h01);
    @(negedge clk);
    busWe = 1'b0;
    #1 check("R8 new page after edge", busRdata, 8'h02);
    busRe = 1'b0;
  endtask

  task automatic t_main_reset;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expectRead("R1 page reg after main reset", 8'h7F, 8'h00);
    expectRead("R7 retention kept 0x1C", 8'h1C, 8'hC0);
    expectRead("R7 retention kept 0x1F", 8'h1F, 8'hC3);
    busWrite(8'h7F, 8'h01);
    expectRead("R1 page1 scratch cleared", 8'h80, 8'h00);
    busWrite(8'h7F, 8'h02);
    expectRead("R1 page2 scratch cleared", 8'h83, 8'h00);
  endtask

  task automatic t_backup_reset;
    @(negedge clk); bkpRstN = 1'b0;
    repeat (2) @(negedge clk);
    bkpRstN = 1'b1;
    for (int i = 0; i < 4; i++) expectRead("R7 retention cleared", 8'h1C + 8'(i), 8'h00);
    expectRead("R7 page reg untouched by backup reset", 8'h7F, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; bkpRstN = 1'b1;
    t_reset();
    t_page_reg();
    t_isolation();
    t_invalid_page();
    t_reserved();
    t_functional();
    t_same_cycle();
    t_main_reset();
    t_backup_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule